// File: doc/BRIEF.md
# Instruction-Byte Serial Register Port

This block is a synchronous serial slave that lets a host controller read and write a bank of 32 eight-bit configuration registers. The block runs entirely on the serial clock. A transfer is framed by an active-low select. It opens with a command byte that gives the direction, a length of one to four bytes and a start address. The data bytes follow, and the block steps the address by itself from byte to byte.

Register 0 holds two mode bits that the port applies to itself. The first chooses the bit order. The second chooses between a shared bidirectional data line and a separate output line. Both bits are sampled when select goes high, so a transfer that rewrites them keeps its own format until it ends. The whole register bank is also presented in parallel on `cfg_q`, so the rest of the chip can use the settings.

Top module: `srp_port`

## Requirements
- R1: After `rst_n` is asserted, every register reads 0. The port is then in MSB-first order and separate-output mode, and both output enables are low.
- R2: The first 8 rising edges of `sclk` after `cs_n` falls shift in the command byte. Bit 7 = 1 means read and 0 means write. Bits 6:5 hold the byte count minus one (00 = 1 byte ... 11 = 4 bytes). Bits 4:0 hold the start address. No register changes during the command byte.
- R3: In a read, each data bit is driven after a falling edge of `sclk`, so the host can sample it on the next rising edge. The first bit appears after the falling edge that follows the 8th rising edge.
- R4: In a write, each data byte is sampled on rising edges and stored at the current address. Register k appears on `cfg_q[8k+7:8k]`.
- R5: In MSB-first order, the address decreases by one after each data byte and wraps from 0 to 31.
- R6: When register 0 bit 6 = 1 (LSB-first), the command byte and the data bytes both travel least significant bit first. The address then increases by one per byte and wraps from 31 to 0.
- R7: While `cs_n` is high, `sdo_en` and `sdio_en` are both low.
- R8: With register 0 bit 7 = 0, read data is driven on `sdo_data` with `sdo_en` high and `sdio_en` low. With bit 7 = 1, read data is driven on `sdio_data` with `sdio_en` high and `sdo_en` low. The two enables are never high together.
- R9: A written byte is visible on `cfg_q` immediately after the rising edge that carries its last bit, while `cs_n` is still low.
- R10: A write to register 0 changes the bit order and the pin mode only from the next transfer onward.
- R11: When `cs_n` rises early, only the fully received data bytes are stored. The next transfer starts again with a fresh command byte.
- R12: Clock edges after the last counted data byte write nothing, and they leave both output enables low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock: input sampled on rise, output changed on fall |
| rst_n | input | 1 | Asynchronous active-low reset of registers and mode |
| cs_n | input | 1 | Active-low transfer frame; high clears the sequencing state |
| sdi | input | 1 | Serial data into the port (receive side of the shared pin in 3-wire use) |
| sdo_data | output | 1 | Read data for the separate output pin |
| sdo_en | output | 1 | Drive enable of the separate output pin |
| sdio_data | output | 1 | Read data for the shared bidirectional pin |
| sdio_en | output | 1 | Drive enable of the shared bidirectional pin |
| cfg_q | output | 256 | Parallel image of all registers, register k at bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: 5 address bits and 8-bit registers, so the command byte is exactly one register wide and wrap-around occurs at 0 and 31. These values let the tests reach both wrap points, write register 0 in the middle of a transfer, and switch among all four order and pin combinations. They also make it possible to cut a transfer off inside a byte and to check the parallel image after each single byte.

// File: rtl/srp_pkg.sv
package srp_pkg;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_IDLE = 2'd2
   } srp_phase_e;

   function automatic logic [7:0] srp_dummy_width();
      return 8'd8;
   endfunction

endpackage

// File: rtl/srp_shift_in.sv
module srp_shift_in #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              lsb_first,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              byte_last,
   output logic [DATA_W-1:0] byte_val
);

   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] sr_nxt;

   always_comb begin
      if (lsb_first) sr_nxt = {sdi, sr_q[DATA_W-1:1]};
      else           sr_nxt = {sr_q[DATA_W-2:0], sdi};
   end

   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         sr_q    <= '0;
         bit_cnt <= '0;
      end else begin
         sr_q    <= sr_nxt;
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign byte_last = (bit_cnt == CNT_W'(DATA_W - 1));
   assign byte_val  = sr_nxt;

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
   import srp_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int LEN_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              lsb_first,
   input  logic              byte_last,
   input  logic [DATA_W-1:0] byte_val,
   output srp_phase_e        phase,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic              rd_active
);

   logic             is_read_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx_q;
   logic [ADDR_W-1:0] addr_step;

   generate
      if (ADDR_W > 1) begin : g_step
         assign addr_step = lsb_first ? addr + 1'b1 : addr - 1'b1;
      end else begin : g_step1
         assign addr_step = ~addr;
      end
   endgenerate

   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         phase     <= PH_CMD;
         is_read_q <= 1'b0;
         len_q     <= '0;
         idx_q     <= '0;
         addr      <= '0;
      end else if (byte_last) begin
         case (phase)
            PH_CMD: begin
               is_read_q <= byte_val[DATA_W-1];
               len_q     <= byte_val[DATA_W-2 -: LEN_W];
               addr      <= byte_val[ADDR_W-1:0];
               idx_q     <= '0;
               phase     <= PH_DATA;
            end
            PH_DATA: begin
               addr  <= addr_step;
               idx_q <= idx_q + 1'b1;
               if (idx_q == len_q) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign wr_en     = !cs_n && byte_last && (phase == PH_DATA) && !is_read_q;
   assign rd_active = (phase == PH_DATA) && is_read_q;

endmodule

// File: rtl/srp_regbank.sv
module srp_regbank #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   localparam int NREG  = 1 << ADDR_W
) (
   input  logic                   sclk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic [NREG*DATA_W-1:0] cfg_q
);

   logic [DATA_W-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (wr_en && (wr_addr == ADDR_W'(i)))
            regs[i] <= wr_data;
      end
      assign cfg_q[i*DATA_W +: DATA_W] = regs[i];
   end

   assign rd_data = regs[rd_addr];

endmodule

// File: rtl/srp_tx.sv
module srp_tx #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              lsb_first,
   input  logic              rd_active,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic [DATA_W-1:0] rd_data,
   output logic              out_bit,
   output logic              out_en
);

   logic [CNT_W-1:0] sel;

   assign sel = lsb_first ? bit_cnt : CNT_W'(DATA_W - 1) - bit_cnt;

   always_ff @(negedge sclk or posedge cs_n) begin
      if (cs_n) begin
         out_bit <= 1'b0;
         out_en  <= 1'b0;
      end else begin
         out_bit <= rd_active ? rd_data[sel] : 1'b0;
         out_en  <= rd_active;
      end
   end

endmodule

// File: rtl/srp_port.sv
module srp_port
   import srp_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int LEN_W        = 2,
   parameter int DATA_W       = 8,
   parameter int MODE_REG     = 0,
   parameter int BIT_3WIRE    = 7,
   parameter int BIT_LSBFIRST = 6,
   localparam int NREG        = 1 << ADDR_W,
   localparam int CNT_W       = $clog2(DATA_W),
   localparam int CMD_W       = 1 + LEN_W + ADDR_W
) (
   input  logic                   sclk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   sdi,
   output logic                   sdo_data,
   output logic                   sdo_en,
   output logic                   sdio_data,
   output logic                   sdio_en,
   output logic [NREG*DATA_W-1:0] cfg_q
);

   if (CMD_W != DATA_W) begin : g_chk_cmd
      $error("srp_port: command fields must fill exactly one data byte");
   end
   if ((1 << CNT_W) != DATA_W) begin : g_chk_pow2
      $error("srp_port: DATA_W must be a power of two");
   end
   if (BIT_3WIRE >= DATA_W || BIT_LSBFIRST >= DATA_W || BIT_3WIRE == BIT_LSBFIRST) begin : g_chk_bits
      $error("srp_port: mode bit positions invalid");
   end
   if (MODE_REG >= NREG) begin : g_chk_mreg
      $error("srp_port: mode register outside bank");
   end

   logic              mode_3wire;
   logic              mode_lsb;
   logic [CNT_W-1:0]  bit_cnt;
   logic              byte_last;
   logic [DATA_W-1:0] byte_val;
   srp_phase_e        phase_q;
   logic              wr_en;
   logic [ADDR_W-1:0] cur_addr;
   logic              rd_active;
   logic [DATA_W-1:0] rd_data;
   logic              out_bit;
   logic              out_en;
   logic [DATA_W-1:0] mode_reg_val;

   assign mode_reg_val = cfg_q[MODE_REG*DATA_W +: DATA_W];

   // Mode bits are taken over when a transfer closes, so they apply from the next one.
   always_ff @(posedge cs_n or negedge rst_n) begin
      if (!rst_n) begin
         mode_3wire <= 1'b0;
         mode_lsb   <= 1'b0;
      end else begin
         mode_3wire <= mode_reg_val[BIT_3WIRE];
         mode_lsb   <= mode_reg_val[BIT_LSBFIRST];
      end
   end

   srp_shift_in #(.DATA_W(DATA_W)) u_shift (
      .sclk      (sclk),
      .cs_n      (cs_n),
      .sdi       (sdi),
      .lsb_first (mode_lsb),
      .bit_cnt   (bit_cnt),
      .byte_last (byte_last),
      .byte_val  (byte_val)
   );

   srp_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
      .sclk      (sclk),
      .cs_n      (cs_n),
      .lsb_first (mode_lsb),
      .byte_last (byte_last),
      .byte_val  (byte_val),
      .phase     (phase_q),
      .wr_en     (wr_en),
      .addr      (cur_addr),
      .rd_active (rd_active)
   );

   srp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .sclk    (sclk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (cur_addr),
      .wr_data (byte_val),
      .rd_addr (cur_addr),
      .rd_data (rd_data),
      .cfg_q   (cfg_q)
   );

   srp_tx #(.DATA_W(DATA_W)) u_tx (
      .sclk      (sclk),
      .cs_n      (cs_n),
      .lsb_first (mode_lsb),
      .rd_active (rd_active),
      .bit_cnt   (bit_cnt),
      .rd_data   (rd_data),
      .out_bit   (out_bit),
      .out_en    (out_en)
   );

   assign sdo_data  = out_bit;
   assign sdio_data = out_bit;
   assign sdo_en    = out_en && !mode_3wire;
   assign sdio_en   = out_en && mode_3wire;

endmodule

// File: rtl/srp_port_chk.sv
module srp_port_chk
   import srp_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   localparam int NREG  = 1 << ADDR_W,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input logic                   sclk,
   input logic                   rst_n,
   input logic                   cs_n,
   input logic                   sdo_en,
   input logic                   sdio_en,
   input logic [NREG*DATA_W-1:0] cfg_q,
   input logic [CNT_W-1:0]       bit_cnt,
   input srp_phase_e             phase_q
);

   a_r7_idle_quiet: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |-> (!sdo_en && !sdio_en));

   a_r8_one_driver: assert property (@(negedge sclk) disable iff (!rst_n)
      !(sdo_en && sdio_en));

   a_r2_cmd_no_write: assert property (@(posedge sclk) disable iff (!rst_n)
      (phase_q == PH_CMD) |=> $stable(cfg_q));

   a_r9_write_at_byte_end: assert property (@(posedge sclk) disable iff (!rst_n)
      (bit_cnt != CNT_W'(DATA_W - 1)) |=> $stable(cfg_q));

   a_r12_tail_no_write: assert property (@(posedge sclk) disable iff (!rst_n)
      (phase_q == PH_IDLE && !cs_n) |=> $stable(cfg_q));

   a_r12_tail_quiet: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
      (phase_q == PH_IDLE) |=> (!sdo_en && !sdio_en));

endmodule

bind srp_port srp_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .sclk    (sclk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .sdo_en  (sdo_en),
   .sdio_en (sdio_en),
   .cfg_q   (cfg_q),
   .bit_cnt (bit_cnt),
   .phase_q (phase_q)
);

// File: tb/srp_port_tb.sv
module srp_port_tb;

   localparam int AW = 5;
   localparam int DW = 8;
   localparam int NR = 1 << AW;

   logic sclk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sdi = 1'b0;
   logic sdo_data, sdo_en, sdio_data, sdio_en;
   logic [NR*DW-1:0] cfg_q;

   int checks = 0;
   int fails = 0;
   bit seen_sdo, seen_sdio;
   logic [7:0] mdl [NR];

   srp_port u_dut (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
      .sdo_data(sdo_data), .sdo_en(sdo_en),
      .sdio_data(sdio_data), .sdio_en(sdio_en), .cfg_q(cfg_q)
   );

   function automatic logic [7:0] cfg(input int a);
      return cfg_q[a*DW +: DW];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bit: data set while sclk low, sampled by the host, then a 4 ns clock period
   task automatic bit_io(input logic b, output logic r);
      sdi = b;
      #1;
      r = sdio_en ? sdio_data : sdo_data;
      seen_sdo  = seen_sdo  | sdo_en;
      seen_sdio = seen_sdio | sdio_en;
      sclk = 1'b1;
      #2;
      sclk = 1'b0;
      #1;
   endtask

   task automatic byte_io(input logic [7:0] v, input bit lsb, output logic [7:0] r);
      r = '0;
      for (int i = 0; i < 8; i++) begin
         int p;
         logic rb;
         p = lsb ? i : 7 - i;
         bit_io(v[p], rb);
         r[p] = rb;
      end
   endtask

   task automatic open_cs();
      cs_n = 1'b0;
      #2;
   endtask

   task automatic close_cs();
      #1;
      cs_n = 1'b1;
      #3;
   endtask

   task automatic xfer(input bit rd, input int n, input logic [4:0] a, input bit lsb,
                       input logic [31:0] wd, output logic [31:0] rdat);
      logic [7:0] r;
      logic [4:0] ad;
      rdat = '0;
      seen_sdo = 1'b0;
      seen_sdio = 1'b0;
      open_cs();
      byte_io({rd, 2'(n - 1), a}, lsb, r);
      ad = a;
      for (int k = 0; k < n; k++) begin
         byte_io(wd[8*k +: 8], lsb, r);
         rdat[8*k +: 8] = r;
         if (!rd) mdl[ad] = wd[8*k +: 8];
         ad = lsb ? ad + 5'd1 : ad - 5'd1;
      end
      close_cs();
   endtask

   task automatic t_reset();
      chk("R1 bank cleared", {31'd0, cfg_q == '0}, 32'd1);
      chk("R1 enables low", {30'd0, sdo_en, sdio_en}, 32'd0);
   endtask

   task automatic t_single_write();
      logic [31:0] rd;
      xfer(1'b0, 1, 5'd5, 1'b0, 32'h0000_00A5, rd);
      chk("R2 R4 single write reg5", cfg(5), 32'hA5);
      chk("R4 neighbour reg4 untouched", cfg(4), 32'h00);
   endtask

   task automatic t_immediate();
      logic [7:0] r;
      open_cs();
      byte_io({1'b0, 2'd1, 5'd9}, 1'b0, r);
      byte_io(8'h5A, 1'b0, r);
      #1;
      chk("R9 visible before cs_n rises", cfg(9), 32'h5A);
      byte_io(8'h33, 1'b0, r);
      close_cs();
      mdl[9] = 8'h5A;
      mdl[8] = 8'h33;
      chk("R5 second byte at addr-1", cfg(8), 32'h33);
   endtask

   task automatic t_msb_wrap();
      logic [31:0] rd;
      xfer(1'b0, 4, 5'd1, 1'b0, 32'h44_33_00_11, rd);
      chk("R5 reg1", cfg(1), 32'h11);
      chk("R5 reg0", cfg(0), 32'h00);
      chk("R5 wrap reg31", cfg(31), 32'h33);
      chk("R5 wrap reg30", cfg(30), 32'h44);
   endtask

   task automatic t_read_4wire();
      logic [31:0] rd;
      xfer(1'b1, 3, 5'd1, 1'b0, 32'h0, rd);
      chk("R3 read bytes msb-first", rd[23:0], 32'h33_00_11);
      chk("R8 4-wire uses sdo", {30'd0, seen_sdo, seen_sdio}, 32'd2);
      chk("R7 idle after cs_n high", {30'd0, sdo_en, sdio_en}, 32'd0);
   endtask

   task automatic t_mode_next();
      logic [31:0] rd;
      xfer(1'b0, 2, 5'd0, 1'b0, 32'h0000_1E40, rd);
      chk("R10 reg0 set", cfg(0), 32'h40);
      chk("R10 same cycle stays msb-first", cfg(31), 32'h1E);
      chk("R10 reg1 untouched", cfg(1), 32'h11);
   endtask

   task automatic t_lsb();
      logic [31:0] rd;
      xfer(1'b0, 3, 5'd30, 1'b1, 32'h00_40_34_12, rd);
      chk("R6 lsb write reg30", cfg(30), 32'h12);
      chk("R6 lsb write reg31", cfg(31), 32'h34);
      chk("R6 wrap to reg0", cfg(0), 32'h40);
      xfer(1'b1, 2, 5'd30, 1'b1, 32'h0, rd);
      chk("R6 lsb read back", rd[15:0], 32'h3412);
   endtask

   task automatic t_3wire();
      logic [31:0] rd;
      xfer(1'b0, 1, 5'd0, 1'b1, 32'h0000_00C0, rd);
      xfer(1'b1, 1, 5'd5, 1'b1, 32'h0, rd);
      chk("R8 3-wire read data", rd[7:0], 32'hA5);
      chk("R8 3-wire uses sdio", {30'd0, seen_sdo, seen_sdio}, 32'd1);
      xfer(1'b0, 1, 5'd0, 1'b1, 32'h0, rd);
      xfer(1'b1, 1, 5'd5, 1'b0, 32'h0, rd);
      chk("R8 back to 4-wire msb-first", {22'd0, seen_sdo, seen_sdio, rd[7:0]}, 32'h2A5);
   endtask

   task automatic t_cut();
      logic [7:0] r;
      logic rb;
      logic [31:0] rd;
      open_cs();
      byte_io({1'b0, 2'd1, 5'd12}, 1'b0, r);
      byte_io(8'h77, 1'b0, r);
      for (int i = 0; i < 4; i++) bit_io(1'b1, rb);
      close_cs();
      mdl[12] = 8'h77;
      chk("R11 full byte kept", cfg(12), 32'h77);
      chk("R11 partial byte dropped", cfg(11), {24'd0, mdl[11]});
      xfer(1'b0, 1, 5'd11, 1'b0, 32'h66, rd);
      chk("R11 fresh cycle after cut", cfg(11), 32'h66);
   endtask

   task automatic t_extra();
      logic [7:0] r;
      open_cs();
      byte_io({1'b0, 2'd0, 5'd20}, 1'b0, r);
      byte_io(8'h99, 1'b0, r);
      byte_io(8'hFF, 1'b0, r);
      close_cs();
      mdl[20] = 8'h99;
      chk("R12 counted byte stored", cfg(20), 32'h99);
      chk("R12 extra byte not stored", cfg(19), {24'd0, mdl[19]});
      open_cs();
      byte_io({1'b1, 2'd0, 5'd20}, 1'b0, r);
      byte_io(8'h00, 1'b0, r);
      chk("R12 read before tail", r, 32'h99);
      seen_sdo = 1'b0;
      seen_sdio = 1'b0;
      byte_io(8'h00, 1'b0, r);
      close_cs();
      chk("R12 tail drives nothing", {30'd0, seen_sdo, seen_sdio}, 32'd0);
   endtask

   task automatic t_full_image();
      int bad;
      bad = 0;
      for (int a = 0; a < NR; a++) if (cfg(a) !== mdl[a]) bad++;
      chk("R4 whole bank matches model", bad, 0);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int a = 0; a < NR; a++) mdl[a] = 8'h00;
      #10;
      rst_n = 1'b1;
      #6;
      t_reset();
      t_single_write();
      t_immediate();
      t_msb_wrap();
      t_read_4wire();
      t_mode_next();
      t_lsb();
      t_3wire();
      t_cut();
      t_extra();
      t_full_image();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule